// File: doc/BRIEF.md
# Streaming Accelerator Job Sequencer

This block is the control state machine at the top of a streaming accelerator. Software leaves a job description on a set of plain configuration pins: a source address, a destination address, a count of input blocks and the number of items held in the final block. It then raises a start flag. The sequencer polls that flag while idle. When it sees the flag high it captures the job description and issues one fetch request per input block, in order. Each request carries the block's address, its item count and a marker on the final block. The processing pipeline reports each finished block with a pulse, and those pulses may arrive while later blocks are still being fetched.

Once every block has been reported as processed, the sequencer issues a single write-back request aimed at the destination address. It waits for the write-back engine to report completion. Only then does it raise a level interrupt, which stays high until software acknowledges it. A cycle counter measures the job's latency. The counter is cleared when the start is accepted, advances on every busy cycle, and freezes when the interrupt rises. It can be read until the next job starts.

Both request outputs are valid/ready streams. A request stays valid until the same cycle in which ready is high, and its address and item count do not change while it waits. A job whose block count is zero skips fetching entirely and goes straight to write-back.

Top module: `job_sequencer`

## Requirements
- R1: After reset, irq, fet_req_valid and wb_req_valid are 0 and cyc_count is 0.
- R2: cfg_start is sampled only while idle. A high level then starts a job in the next cycle. While a job is running or an interrupt is pending, cfg_start has no effect: no extra requests are issued and the job does not restart.
- R3: A job with block count Q issues exactly Q fetch handshakes. Block i (counting from 0) has address src + i*K*ITEM_BYTES. A request held back by fet_req_ready low keeps fet_req_valid, fet_req_addr and fet_req_items unchanged until it is accepted.
- R4: fet_req_items is K for every block except the final one, which carries the final-block item count with fet_req_last = 1. fet_req_last is 0 on every other block.
- R5: The source address, destination address, block count and final-block count are captured when the start is accepted. Later changes on the cfg pins do not affect the running job.
- R6: The write-back request is issued only after Q blk_done pulses have been received during the job. It carries the captured destination address and is never valid together with a fetch request.
- R7: irq rises only after a wb_done that follows the write-back handshake. irq stays high until cfg_ack is high in a cycle with irq high, and drops in the following cycle. cfg_ack at any other time is ignored.
- R8: With Q = 0, no fetch request is issued and the job proceeds directly to write-back.
- R9: cyc_count, read while irq is high, equals the number of clock cycles between the edge that accepted the start and the edge that raised irq. It stays unchanged while irq is high, and it is cleared by the next accepted start.
- R10: A blk_done pulse in the same cycle as a fetch handshake is counted. Both events take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start flag, polled while idle |
| cfg_ack | input | 1 | Interrupt acknowledge |
| cfg_src_addr | input | AW | Source address of block 0 |
| cfg_dst_addr | input | AW | Destination address for the results |
| cfg_nblocks | input | QW | Number of input blocks Q |
| cfg_last_items | input | CW | Item count of the final block (1..K) |
| fet_req_valid | output | 1 | Fetch request valid |
| fet_req_ready | input | 1 | Fetch engine accepts the request |
| fet_req_addr | output | AW | Address of the requested block |
| fet_req_items | output | CW | Valid items in the requested block |
| fet_req_last | output | 1 | Request is the final block |
| blk_done | input | 1 | One block finished processing (pulse) |
| wb_req_valid | output | 1 | Write-back request valid |
| wb_req_ready | input | 1 | Write-back engine accepts the request |
| wb_req_addr | output | AW | Destination address of the write-back |
| wb_done | input | 1 | Write-back finished (pulse) |
| irq | output | 1 | Job-complete interrupt, level |
| cyc_count | output | TW | Job latency in clock cycles |

## Verification
Two events can fall in the same cycle: a fetch handshake for one block and the blk_done pulse for an earlier or even the same block. The bench provokes this by returning each block's done pulse a fixed delay after its handshake, with delays of zero, one and three cycles, so that the pulse coincides with later handshakes or with its own. It judges the outcome through the write-back timing and the latency count, which must match the arithmetic sum of Q fetch cycles, the drain delay and the write-back delay. A lost or double-counted pulse would move the write-back or hang the job.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_DRAIN = 3'd2,
    ST_WB    = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       q_zero,
  input  logic       issue_last,
  input  logic       all_processed,
  input  logic       wb_ready,
  input  logic       wb_done,
  input  logic       ack,
  output seq_state_t state,
  output logic       load,
  output logic       wb_valid
);
  seq_state_t nxt;
  logic       wb_sent;

  assign load     = (state == ST_IDLE) && start;
  assign wb_valid = (state == ST_WB) && !wb_sent;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = q_zero ? ST_WB : ST_FETCH;
      ST_FETCH: if (issue_last) nxt = ST_DRAIN;
      ST_DRAIN: if (all_processed) nxt = ST_WB;
      ST_WB:    if (wb_sent && wb_done) nxt = ST_DONE;
      ST_DONE:  if (ack) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wb_sent <= 1'b0;
    end else begin
      state <= nxt;
      if (wb_valid && wb_ready) wb_sent <= 1'b1;
      else if (state == ST_WB && wb_sent && wb_done) wb_sent <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_blk_gen.sv
module seq_blk_gen
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW = 16,
  parameter int CW = 4,
  parameter int K  = 8,
  parameter int BLK_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state,
  input  logic          load,
  input  logic [AW-1:0] src_in,
  input  logic [QW-1:0] q_in,
  input  logic [CW-1:0] last_in,
  input  logic          req_ready,
  input  logic          blk_done,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [CW-1:0] req_items,
  output logic          req_last,
  output logic          issue_last,
  output logic          all_processed
);
  localparam logic [CW-1:0] K_ITEMS = CW'(K);
  localparam logic [AW-1:0] STEP    = AW'(BLK_BYTES);

  logic [AW-1:0] addr_r;
  logic [QW-1:0] q_r;
  logic [QW-1:0] idx_r;
  logic [QW-1:0] proc_r;
  logic [CW-1:0] last_r;
  logic          hs;
  logic          in_flight;

  assign req_valid     = (state == ST_FETCH);
  assign hs            = req_valid && req_ready;
  assign req_last      = ({1'b0, idx_r} + 1'b1) == {1'b0, q_r};
  assign req_items     = req_last ? last_r : K_ITEMS;
  assign req_addr      = addr_r;
  assign issue_last    = hs && req_last;
  assign all_processed = (proc_r == q_r);
  assign in_flight     = (state == ST_FETCH) || (state == ST_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      q_r    <= '0;
      idx_r  <= '0;
      proc_r <= '0;
      last_r <= '0;
    end else if (load) begin
      addr_r <= src_in;
      q_r    <= q_in;
      idx_r  <= '0;
      proc_r <= '0;
      last_r <= last_in;
    end else begin
      if (hs) begin
        idx_r  <= idx_r + 1'b1;
        addr_r <= addr_r + STEP;
      end
      if (blk_done && in_flight && !all_processed) proc_r <= proc_r + 1'b1;
    end
  end
endmodule

// File: rtl/seq_cyc_ctr.sv
module seq_cyc_ctr
  import seq_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state,
  input  logic          load,
  output logic [TW-1:0] count
);
  logic busy;
  assign busy = (state == ST_FETCH) || (state == ST_DRAIN) || (state == ST_WB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= '0;
    else if (busy)  count <= count + 1'b1;
  end
endmodule

// File: rtl/job_sequencer.sv
module job_sequencer
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW = 16,
  parameter int K  = 8,
  parameter int ITEM_BYTES = 4,
  parameter int TW = 32,
  parameter int CW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_ack,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [QW-1:0] cfg_nblocks,
  input  logic [CW-1:0] cfg_last_items,
  output logic          fet_req_valid,
  input  logic          fet_req_ready,
  output logic [AW-1:0] fet_req_addr,
  output logic [CW-1:0] fet_req_items,
  output logic          fet_req_last,
  input  logic          blk_done,
  output logic          wb_req_valid,
  input  logic          wb_req_ready,
  output logic [AW-1:0] wb_req_addr,
  input  logic          wb_done,
  output logic          irq,
  output logic [TW-1:0] cyc_count
);
  localparam int BLK_BYTES = K * ITEM_BYTES;

  seq_state_t    state;
  logic          load;
  logic          issue_last;
  logic          all_processed;
  logic [AW-1:0] dst_r;

  seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (cfg_start),
    .q_zero        (cfg_nblocks == '0),
    .issue_last    (issue_last),
    .all_processed (all_processed),
    .wb_ready      (wb_req_ready),
    .wb_done       (wb_done),
    .ack           (cfg_ack),
    .state         (state),
    .load          (load),
    .wb_valid      (wb_req_valid)
  );

  seq_blk_gen #(
    .AW(AW), .QW(QW), .CW(CW), .K(K), .BLK_BYTES(BLK_BYTES)
  ) u_blk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .load          (load),
    .src_in        (cfg_src_addr),
    .q_in          (cfg_nblocks),
    .last_in       (cfg_last_items),
    .req_ready     (fet_req_ready),
    .blk_done      (blk_done),
    .req_valid     (fet_req_valid),
    .req_addr      (fet_req_addr),
    .req_items     (fet_req_items),
    .req_last      (fet_req_last),
    .issue_last    (issue_last),
    .all_processed (all_processed)
  );

  seq_cyc_ctr #(.TW(TW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .load  (load),
    .count (cyc_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dst_r <= '0;
    else if (load) dst_r <= cfg_dst_addr;
  end

  assign wb_req_addr = dst_r;
  assign irq         = (state == ST_DONE);
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ack,
  input logic          fet_req_valid,
  input logic          fet_req_ready,
  input logic [AW-1:0] fet_req_addr,
  input logic [CW-1:0] fet_req_items,
  input logic          wb_req_valid,
  input logic          wb_req_ready,
  input logic [AW-1:0] wb_req_addr,
  input logic          irq,
  input logic [TW-1:0] cyc_count
);
  // R3
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fet_req_valid && !fet_req_ready |=> fet_req_valid && $stable(fet_req_addr) && $stable(fet_req_items));

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && !wb_req_ready |=> wb_req_valid && $stable(wb_req_addr));

  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req_valid && fet_req_valid));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_ack |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && cfg_ack |=> !irq);

  // R9
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_ack |=> $stable(cyc_count));

  // R2
  no_req_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !fet_req_valid && !wb_req_valid);
endmodule

bind job_sequencer seq_chk #(.AW(AW), .CW(CW), .TW(TW)) u_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_ack       (cfg_ack),
  .fet_req_valid (fet_req_valid),
  .fet_req_ready (fet_req_ready),
  .fet_req_addr  (fet_req_addr),
  .fet_req_items (fet_req_items),
  .wb_req_valid  (wb_req_valid),
  .wb_req_ready  (wb_req_ready),
  .wb_req_addr   (wb_req_addr),
  .irq           (irq),
  .cyc_count     (cyc_count)
);

// File: tb/tb_job_sequencer.sv
module tb_job_sequencer;
  localparam int AW = 32, QW = 16, K = 8, IB = 4, TW = 32;
  localparam int CW = $clog2(K + 1);
  localparam int BLK = K * IB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start = 0, cfg_ack = 0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [QW-1:0] cfg_nblocks = '0;
  logic [CW-1:0] cfg_last_items = '0;
  logic fet_req_valid, fet_req_ready = 0, fet_req_last;
  logic [AW-1:0] fet_req_addr, wb_req_addr;
  logic [CW-1:0] fet_req_items;
  logic blk_done = 0, wb_req_valid, wb_req_ready = 0, wb_done = 0, irq;
  logic [TW-1:0] cyc_count;

  int checks = 0, fails = 0;
  bit sched_b[0:255];
  bit sched_w[0:255];

  always #2.5 clk = ~clk;

  job_sequencer dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic run_job(input int q, input int d, input int w, input bit stall);
    logic [AW-1:0] src, dst;
    int last, hs_n, done_n, k, exp_cnt, measured;
    bit prev_stall;
    logic [AW-1:0] prev_addr;
    src = 32'h1000_0000 + q * 32'h100 + d * 16;
    dst = 32'h8000_0000 + w * 32'h40 + q;
    last = ((q + d) % K) + 1;
    for (int i = 0; i < 256; i++) begin sched_b[i] = 0; sched_w[i] = 0; end
    @(negedge clk);
    cfg_src_addr = src; cfg_dst_addr = dst;
    cfg_nblocks = QW'(q); cfg_last_items = CW'(last);
    cfg_start = 1;
    hs_n = 0; done_n = 0; k = 0; measured = -1; prev_stall = 0; prev_addr = '0;
    while (k < 200) begin
      @(negedge clk);
      if (k == 0) begin
        cfg_start = 0;
        // R5: scramble the configuration after acceptance
        cfg_src_addr = 32'hDEAD_0000; cfg_dst_addr = 32'hBEEF_0000;
        cfg_nblocks = 16'd9; cfg_last_items = CW'(1);
      end
      cfg_start = (k == 2);   // R2: start while busy
      cfg_ack   = (k == 1);   // R7: ack while busy
      fet_req_ready = stall ? ((k % 3) != 1) : 1'b1;
      wb_req_ready  = stall ? ((k % 2) == 1) : 1'b1;
      #0.5;
      if (irq) begin measured = k; break; end
      if (prev_stall) chk(fet_req_valid && fet_req_addr == prev_addr, "R3 hold", fet_req_addr, prev_addr);
      prev_stall = fet_req_valid && !fet_req_ready;
      prev_addr  = fet_req_addr;
      if (fet_req_valid && fet_req_ready) begin
        chk(fet_req_addr == src + AW'(hs_n * BLK), "R3 addr", fet_req_addr, src + AW'(hs_n * BLK));
        chk(fet_req_items == CW'((hs_n == q - 1) ? last : K), "R4 items", fet_req_items, (hs_n == q - 1) ? last : K);
        chk(fet_req_last == (hs_n == q - 1), "R4 last", fet_req_last, hs_n == q - 1);
        sched_b[k + d] = 1;
        hs_n++;
      end
      if (wb_req_valid && wb_req_ready) begin
        chk(wb_req_addr == dst, "R6 addr", wb_req_addr, dst);
        chk(done_n == q, "R6 order", done_n, q);
        sched_w[k + w] = 1;
      end
      blk_done = sched_b[k];
      if (blk_done) done_n++;
      wb_done = sched_w[k];
      k++;
    end
    blk_done = 0; wb_done = 0; cfg_ack = 0; cfg_start = 0;
    chk(measured >= 0, "R7 irq", measured, 1);
    chk(hs_n == q, (q == 0) ? "R8 fetches" : "R3 count", hs_n, q);
    exp_cnt = (q == 0) ? w + 1 : q + d + 2 + w;
    if (!stall) chk(cyc_count == TW'(exp_cnt), "R10 R9 sum", cyc_count, exp_cnt);
    chk(cyc_count == TW'(measured), "R9 measured", cyc_count, measured);
    repeat (3) @(negedge clk);
    #0.5;
    chk(irq == 1'b1, "R7 level", irq, 1);
    chk(cyc_count == TW'(measured), "R9 frozen", cyc_count, measured);
    @(negedge clk); cfg_ack = 1;
    @(negedge clk); cfg_ack = 0;
    #0.5;
    chk(irq == 1'b0, "R7 cleared", irq, 0);
    repeat (2) @(negedge clk);
    #0.5;
    chk(!fet_req_valid && !wb_req_valid && !irq, "R2 no restart", fet_req_valid | wb_req_valid, 0);
  endtask

  initial begin
    #1;
    chk(irq == 0 && !fet_req_valid && !wb_req_valid && cyc_count == 0, "R1 reset", cyc_count, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #0.5;
    chk(irq == 0 && !fet_req_valid && !wb_req_valid && cyc_count == 0, "R1 idle", irq, 0);
    for (int st = 0; st < 2; st++)
      for (int q = 0; q <= 5; q++)
        for (int di = 0; di < 3; di++)
          for (int w = 1; w <= 2; w++)
            run_job(q, (di == 2) ? 3 : di, w, st[0]);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule